// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block holds the interrupt event flags of a network controller, together with a mask that gates them. Event sources elsewhere in the controller raise a flag with a one-cycle pulse. Software reads the flags and clears them by writing ones. The gated flags are spread out to thirteen separate level interrupt lines, one per source, through a fixed routing.

Register accesses use a simple word-addressed port. A write lands in the cycle it is presented. A read is combinational on the read address. A write to the transmit control address with bit 0 set raises the graceful-stop-complete flag at once, because the transmitter this block serves stops without delay. A synchronous controller reset input clears the flags and the mask without touching the rest of the chip.

Top module: `irq_event_ctrl`

## Requirements
- R1: Word address 0 reads the event register. Flags sit in bits 31..19: heartbeat 31, babbling receive 30, babbling transmit 29, graceful stop 28, transmit frame 27, transmit buffer 26, receive frame 25, receive buffer 24, MII 23, bus error 22, late collision 21, retry limit 20, underrun 19. Bits 18..0 read 0, and any address other than 0 and 1 reads 0.
- R2: A write to address 0 clears every flag whose bit in the written word is 1. Flags written with 0 keep their value.
- R3: Address 1 is the mask register. A write stores bits 31..19 and a read returns them. Bits 18..0 read 0.
- R4: An interrupt line is active only when both its flag and its mask bit are 1.
- R5: Lines 0 to 12 carry, in order: transmit frame, transmit buffer, underrun, retry limit, receive frame, receive buffer, MII, late collision, heartbeat, graceful stop, bus error, babbling transmit, babbling receive.
- R6: A write to address 2 with bit 0 set raises the graceful-stop flag (bit 28). With bit 0 clear, the write changes nothing.
- R7: rst_n low, or soft_rst high at a clock edge, clears the event and mask registers. The lines fall one cycle later.
- R8: If a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R9: Each line is registered. It changes one clock after the flag or mask change that causes it.
- R10: evt_set[i] high at an edge sets the flag at bit 19+i. The flag stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous controller reset, clears event and mask registers |
| evt_set | input | 13 | One pulse per source; bit i raises the flag at bit 19+i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data |
| irq_line | output | 13 | Per-source level interrupt lines |

## Verification
Each source is pulsed alone with the mask fully open. This shows that every line follows exactly one flag and exposes any swap in the routing. With all flags set, the mask is then opened one bit at a time, which separates the mask gating from the routing. Clear writes with alternating bit patterns, and with all zeros, show that only written ones clear flags. A set and a clear aimed at the same flag in the same cycle, plus cycle-exact samples taken between the register update and the line update, confirm the priority and the one-clock line delay.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  localparam int NUM_SRC = 13;
  localparam int EVT_LSB = 19;

  // flag index = register bit - EVT_LSB
  localparam int SRC_UNDERRUN = 0;
  localparam int SRC_RETRY    = 1;
  localparam int SRC_LATECOL  = 2;
  localparam int SRC_BUSERR   = 3;
  localparam int SRC_MGMT     = 4;
  localparam int SRC_RXBUF    = 5;
  localparam int SRC_RXFRM    = 6;
  localparam int SRC_TXBUF    = 7;
  localparam int SRC_TXFRM    = 8;
  localparam int SRC_GSTOP    = 9;
  localparam int SRC_BABTX    = 10;
  localparam int SRC_BABRX    = 11;
  localparam int SRC_HBEAT    = 12;

  localparam int OFF_EVENT = 0;
  localparam int OFF_MASK  = 1;
  localparam int OFF_TXCTL = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // which flag feeds interrupt line 'line'
  function automatic int line_source(input int line);
    case (line)
      0:       return SRC_TXFRM;
      1:       return SRC_TXBUF;
      2:       return SRC_UNDERRUN;
      3:       return SRC_RETRY;
      4:       return SRC_RXFRM;
      5:       return SRC_RXBUF;
      6:       return SRC_MGMT;
      7:       return SRC_LATECOL;
      8:       return SRC_HBEAT;
      9:       return SRC_GSTOP;
      10:      return SRC_BUSERR;
      11:      return SRC_BABTX;
      default: return SRC_BABRX;
    endcase
  endfunction

  // next flag value: clears applied first, then sets so a set is never lost
  function automatic src_vec_t next_flags(input src_vec_t cur,
                                          input src_vec_t clr,
                                          input src_vec_t set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  src_vec_t          evt_q,
  input  src_vec_t          mask_q,
  output src_vec_t          evt_clr,
  output logic              mask_wr,
  output src_vec_t          mask_val,
  output logic              gstop_req,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(OFF_EVENT);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_TXCTL = ADDR_W'(OFF_TXCTL);

  function automatic logic [DATA_W-1:0] place(input src_vec_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EVT_LSB +: NUM_SRC] = v;
    return w;
  endfunction

  logic wr_event, wr_txctl;

  always_comb begin
    wr_event  = wr_en && (wr_addr == A_EVENT);
    mask_wr   = wr_en && (wr_addr == A_MASK);
    wr_txctl  = wr_en && (wr_addr == A_TXCTL);
    evt_clr   = wr_event ? wr_data[EVT_LSB +: NUM_SRC] : '0;
    mask_val  = wr_data[EVT_LSB +: NUM_SRC];
    gstop_req = wr_txctl && wr_data[0];
  end

  always_comb begin
    case (rd_addr)
      A_EVENT: rd_data = place(evt_q);
      A_MASK:  rd_data = place(mask_q);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
  import irq_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  src_vec_t set_vec,
  input  src_vec_t clr_vec,
  input  logic     mask_wr,
  input  src_vec_t mask_val,
  output src_vec_t evt_q,
  output src_vec_t mask_q
);

  src_vec_t evt_d;

  always_comb evt_d = next_flags(evt_q, clr_vec, set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else if (soft_rst) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (mask_wr) mask_q <= mask_val;
    end
  end

  // R8 / R10: every pulsed flag is set afterwards, clear or not
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_vec) && !soft_rst) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  // R2: only written ones clear
  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_vec) && (set_vec == '0) && !soft_rst)
      |=> (evt_q == ($past(evt_q) & ~$past(clr_vec))));

  // R10: flags hold without set or clear
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec == '0) && (set_vec == '0) && !soft_rst) |=> $stable(evt_q));

  // R3: mask takes the written value
  assert_mask_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !soft_rst) |=> (mask_q == $past(mask_val)));

  // R7: controller reset empties both registers
  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((evt_q == '0) && (mask_q == '0)));

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt_q,
  input  src_vec_t mask_q,
  output src_vec_t irq_line
);

  src_vec_t active;
  src_vec_t routed;

  always_comb active = evt_q & mask_q;

  for (genvar l = 0; l < NUM_SRC; l++) begin : g_line
    localparam int SRC = line_source(l);
    always_comb routed[l] = active[SRC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_line <= '0;
    else        irq_line <= routed;
  end

  // R4 / R9: one clock later, the count of raised lines equals the count of gated flags
  assert_line_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(irq_line) == $countones($past(evt_q & mask_q))));

  // R4: no line without some flag gated through
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) == '0) |-> (irq_line == '0));

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NUM_SRC-1:0]  evt_set,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_SRC-1:0]  irq_line
);

  src_vec_t evt_q, mask_q, evt_clr, mask_val, set_all, gstop_vec;
  logic     mask_wr, gstop_req;

  irq_reg_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .evt_clr   (evt_clr),
    .mask_wr   (mask_wr),
    .mask_val  (mask_val),
    .gstop_req (gstop_req),
    .rd_data   (rd_data)
  );

  always_comb begin
    gstop_vec = '0;
    gstop_vec[SRC_GSTOP] = gstop_req;
    set_all = evt_set | gstop_vec;
  end

  irq_event_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_vec  (set_all),
    .clr_vec  (evt_clr),
    .mask_wr  (mask_wr),
    .mask_val (mask_val),
    .evt_q    (evt_q),
    .mask_q   (mask_q)
  );

  irq_line_router u_router (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_q    (evt_q),
    .mask_q   (mask_q),
    .irq_line (irq_line)
  );

  // R6: a stop request raises the graceful-stop flag on the next edge
  assert_gstop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gstop_req && !soft_rst) |=> evt_q[SRC_GSTOP]);

  // R5: graceful-stop line tracks its own flag and mask bit only
  assert_gstop_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line[9] == $past(evt_q[SRC_GSTOP] & mask_q[SRC_GSTOP])));

endmodule

// File: tb/irq_event_ctrl_bench.sv
`timescale 1ns/1ps
module irq_event_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [12:0] evt_set = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [12:0] irq_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_event_ctrl u_irq_event_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_set(evt_set),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_line(irq_line)
  );

  // register bit carrying interrupt line n (R5 order, R1 positions)
  function automatic int line_bit(input int n);
    int order [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return order[n];
  endfunction

  function automatic logic [12:0] expect_lines(input logic [31:0] ev, input logic [31:0] mk);
    logic [12:0] r;
    for (int n = 0; n < 13; n++) r[n] = ev[line_bit(n)] & mk[line_bit(n)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [12:0] s);
    evt_set = s;
    tick();
    evt_set = '0;
  endtask

  localparam logic [31:0] ALL = 32'hFFF8_0000;

  initial begin
    logic [31:0] v, ev, mk;
    @(negedge clk);
    tick();
    // R7 reset state
    rd(4'd0, v); chk("R7 event after reset", v, 32'h0);
    rd(4'd1, v); chk("R7 mask after reset", v, 32'h0);
    chk("R7 lines after reset", {19'h0, irq_line}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R3 mask storage
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R3 mask readback", v, ALL);
    rd(4'd5, v); chk("R1 unmapped read zero", v, 32'h0);
    mk = ALL;

    // R10 / R5 per-source routing sweep
    for (int s = 0; s < 13; s++) begin
      ev = 32'h1 << (19 + s);
      pulse(13'h1 << s);
      rd(4'd0, v); chk($sformatf("R10 flag %0d set", s), v, ev);
      tick();
      chk($sformatf("R5 route source %0d", s), {19'h0, irq_line}, {19'h0, expect_lines(ev, mk)});
      wr(4'd0, ev);
      rd(4'd0, v); chk($sformatf("R2 clear flag %0d", s), v, 32'h0);
      tick();
      chk($sformatf("R4 line drop %0d", s), {19'h0, irq_line}, 32'h0);
    end

    // R4 mask gating sweep with all flags set
    pulse(13'h1FFF);
    ev = ALL;
    for (int m = 0; m < 13; m++) begin
      mk = 32'h1 << (19 + m);
      wr(4'd1, mk | 32'h0000_5555);
      tick();
      chk($sformatf("R4 mask bit %0d", m), {19'h0, irq_line}, {19'h0, expect_lines(ev, mk)});
    end

    // R2 partial clears
    wr(4'd0, 32'hAAAA_AAAA);
    ev = ALL & ~32'hAAAA_AAAA;
    rd(4'd0, v); chk("R2 alternating clear", v, ev);
    wr(4'd0, 32'h0);
    rd(4'd0, v); chk("R2 zero write keeps flags", v, ev);
    wr(4'd0, 32'h5555_5555);
    rd(4'd0, v); chk("R2 complement clear", v, 32'h0);

    // R8 set and clear collide
    evt_set = 13'h0101;
    wr(4'd0, ALL);
    evt_set = '0;
    rd(4'd0, v); chk("R8 set wins", v, (32'h1 << 19) | (32'h1 << 27));
    wr(4'd0, ALL);

    // R9 registered line timing
    wr(4'd1, ALL);
    tick();
    evt_set = 13'h0040;
    tick();
    evt_set = '0;
    rd(4'd0, v); chk("R9 flag visible", v, 32'h1 << 25);
    chk("R9 line not yet", {19'h0, irq_line}, 32'h0);
    tick();
    chk("R9 line one clock later", {19'h0, irq_line}, 32'h10);
    wr(4'd0, ALL);
    tick();

    // R6 graceful stop hook
    wr(4'd2, 32'h0000_0002);
    rd(4'd0, v); chk("R6 bit0 clear ignored", v, 32'h0);
    tick();
    chk("R6 no line on ignored write", {19'h0, irq_line}, 32'h0);
    wr(4'd2, 32'h0000_0001);
    rd(4'd0, v); chk("R6 stop sets flag", v, 32'h1000_0000);
    tick();
    chk("R6 stop line", {19'h0, irq_line}, 32'h200);

    // R7 controller reset
    pulse(13'h1FFF);
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    rd(4'd0, v); chk("R7 soft reset event", v, 32'h0);
    rd(4'd1, v); chk("R7 soft reset mask", v, 32'h0);
    tick();
    chk("R7 soft reset lines", {19'h0, irq_line}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule